// File: doc/BRIEF.md
# Brownout and Reset Source Controller

This block collects the reset sources of a device and turns them into one system reset with a record of its cause. It runs an external supply comparator through a small state machine and selects the comparator's operating mode from one of two 2-bit configuration fields. The first field governs the active and idle states. The second governs the deeper sleep states. The comparator can be off, on all the time, or powered only for a short window on each slow tick. A brownout caught in that sampled mode switches the comparator to continuous operation, and the reset stays held until the supply flag clears.

An active-low external reset pin is synchronised and then length-filtered, so a short glitch is ignored. A watchdog timeout event is stretched into a reset pulse measured in periods of a fast clock enable. The brownout, external and watchdog sources are ORed into a registered system reset. A sticky cause register records which source fired. Software clears that register by writing ones, and the system reset it records does not clear it.

Brownout state machine states are `BS_OFF`, `BS_ON`, `BS_WAIT`, `BS_SAMPLE` and `BS_HOLD`:
- Each of `BS_OFF`, `BS_ON` and `BS_WAIT` moves to the state that matches a new mode. That is `BS_ON` for enabled, `BS_WAIT` for sampled, and `BS_OFF` for the other two codes.
- `BS_WAIT` moves to `BS_SAMPLE` on a slow tick.
- `BS_SAMPLE` moves to `BS_HOLD` when the synchronised flag is high. It moves back to `BS_WAIT` when the window ends, or to the mode's own state if the mode has changed.
- `BS_HOLD` moves to the mode's state only when the flag is low.

Pin filter states are `EX_IDLE`, `EX_COUNT` and `EX_ASSERT`:
- A low sample moves the filter out of `EX_IDLE`.
- The filter reaches `EX_ASSERT` after the minimum number of consecutive low samples.
- Any high sample returns the filter to `EX_IDLE`.

Watchdog stretcher states are `WD_IDLE`, `WD_FIRST` and `WD_SECOND`:
- A timeout event moves the stretcher to `WD_FIRST`.
- Each fast tick then advances it one state, through `WD_SECOND` and back to `WD_IDLE`.

Top module: `rst_src_ctrl`

## Requirements
- R1: Mode codes decode as 2'b11 = continuous, 2'b01 = sampled, and 2'b10 or 2'b00 = off. In the off modes `bod_en` stays 0 and `bod_flag` causes no reset and sets no cause bit.
- R2: While `sleep_deep` is 0 the latched `cfg_act` field sets the mode. While `sleep_deep` is 1 the latched `cfg_pd` field sets it. A field is latched on a cycle where `cfg_load` is 1.
- R3: In sampled mode, each `slow_tick` pulse drives `bod_en` and `bod_sample` high for exactly `SAMPLE_CYC` cycles, and both are low between ticks. A flag pulse that lies wholly between two windows causes no reset.
- R4: In continuous mode, `bod_en` is 1, and `sys_rst` is high for as long as `bod_flag` is high, following it after the synchroniser delay.
- R5: A flag seen during a sample window keeps `bod_en` and `sys_rst` at 1 until `bod_flag` returns low, even if the configuration changes meanwhile.
- R6: A low on `ext_rst_n` that lasts L cycles raises `sys_rst` only if L >= `EXT_MIN`. When it does, `sys_rst` stays high for L - `EXT_MIN` + 1 cycles.
- R7: A single-cycle `wdt_timeout` with `fast_tick` every P cycles gives a `sys_rst` pulse of N cycles, where P < N <= 2P.
- R8: `sys_rst` is 1 while `rst_n` is low. Until the first `cfg_load`, the detector runs in continuous mode (`bod_en` = 1).
- R9: `cause` bit 0 records brownout, bit 1 external pin and bit 2 watchdog. A bit is set while its source is active and cleared by writing 1 to the matching bit of `cause_clr`, but a set wins over a clear in the same cycle. `sys_rst` never clears the register, and `rst_n` zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| slow_tick | input | 1 | One-cycle pulse at the 1 kHz slow rate |
| fast_tick | input | 1 | One-cycle pulse at the 2 MHz fast rate |
| sleep_deep | input | 1 | 1 when the device is in a sleep state other than idle |
| cfg_load | input | 1 | Latches both mode fields |
| cfg_act | input | 2 | Brownout mode for active and idle |
| cfg_pd | input | 2 | Brownout mode for the other sleep states |
| bod_flag | input | 1 | Asynchronous comparator output, 1 = supply low |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| wdt_timeout | input | 1 | One-cycle watchdog timeout event |
| cause_clr | input | 3 | Write-one-to-clear strobes for `cause` |
| bod_en | output | 1 | Comparator power enable |
| bod_sample | output | 1 | High during a sampled-mode window |
| sys_rst | output | 1 | System reset, active high |
| cause | output | 3 | Sticky reset cause flags |

## Verification
The assertions assume the following about the inputs:
- `slow_tick`, `fast_tick` and `wdt_timeout` are single-cycle pulses.
- A new watchdog event does not arrive while a stretched pulse is running.
- `cfg_act`, `cfg_pd` and `sleep_deep` are synchronous to `clk`.

The bench generates the fast tick from a free-running counter and keeps the slow tick and the watchdog event one cycle wide. It drives every input just after a falling edge, so each input is stable at the sampling edge. It issues watchdog events only after the previous pulse has ended. All sixteen field pairs are swept under both sleep selections.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;

    typedef enum logic [1:0] {
        BOD_RSVD     = 2'b00,
        BOD_SAMPLED  = 2'b01,
        BOD_DISABLED = 2'b10,
        BOD_ENABLED  = 2'b11
    } bod_mode_e;

    typedef enum logic [2:0] {
        BS_OFF,
        BS_ON,
        BS_WAIT,
        BS_SAMPLE,
        BS_HOLD
    } bod_state_e;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_COUNT,
        EX_ASSERT
    } ext_state_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_FIRST,
        WD_SECOND
    } wdt_state_e;

    localparam int CAUSE_BOD = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_W   = 3;

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            stab_q <= INIT;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl
    import rst_src_pkg::*;
#(
    parameter int SAMPLE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       sleep_deep,
    input  logic       cfg_load,
    input  logic [1:0] cfg_act,
    input  logic [1:0] cfg_pd,
    input  logic       bod_s,
    output logic       bod_en,
    output logic       bod_sample,
    output logic       bod_rst
);

    localparam int WCW = (SAMPLE_CYC < 2) ? 1 : $clog2(SAMPLE_CYC);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(SAMPLE_CYC - 1);

    logic [1:0]     act_q, pd_q;
    logic           cfg_seen_q;
    bod_mode_e      mode;
    bod_state_e     base_st;
    bod_state_e     st_q, st_d;
    logic [WCW-1:0] win_q, win_d;

    // configuration latch; the enabled mode holds until the first load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q      <= 2'b11;
            pd_q       <= 2'b11;
            cfg_seen_q <= 1'b0;
        end else if (cfg_load) begin
            act_q      <= cfg_act;
            pd_q       <= cfg_pd;
            cfg_seen_q <= 1'b1;
        end
    end

    always_comb begin
        if (!cfg_seen_q) begin
            mode = BOD_ENABLED;
        end else if (sleep_deep) begin
            mode = bod_mode_e'(pd_q);
        end else begin
            mode = bod_mode_e'(act_q);
        end
    end

    always_comb begin
        unique case (mode)
            BOD_ENABLED:               base_st = BS_ON;
            BOD_SAMPLED:               base_st = BS_WAIT;
            BOD_DISABLED, BOD_RSVD:    base_st = BS_OFF;
            default:                   base_st = BS_OFF;
        endcase
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        win_d = win_q;
        unique case (st_q)
            BS_OFF, BS_ON: begin
                if (base_st != st_q) st_d = base_st;
            end
            BS_WAIT: begin
                if (base_st != BS_WAIT) begin
                    st_d = base_st;
                end else if (slow_tick) begin
                    st_d  = BS_SAMPLE;
                    win_d = '0;
                end
            end
            BS_SAMPLE: begin
                if (bod_s) begin
                    st_d = BS_HOLD;
                end else if (base_st != BS_WAIT) begin
                    st_d = base_st;
                end else if (win_q == WIN_LAST) begin
                    st_d = BS_WAIT;
                end else begin
                    win_d = win_q + 1'b1;
                end
            end
            BS_HOLD: begin
                if (!bod_s) st_d = base_st;
            end
            default: st_d = BS_ON;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BS_ON;
            win_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
        end
    end

    // outputs
    always_comb begin
        bod_en     = 1'b0;
        bod_sample = 1'b0;
        bod_rst    = 1'b0;
        unique case (st_q)
            BS_ON: begin
                bod_en  = 1'b1;
                bod_rst = bod_s;
            end
            BS_SAMPLE: begin
                bod_en     = 1'b1;
                bod_sample = 1'b1;
            end
            BS_HOLD: begin
                bod_en  = 1'b1;
                bod_rst = 1'b1;
            end
            default: ;
        endcase
    end

    AST_HOLD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_HOLD && bod_s) |=> (st_q == BS_HOLD)); // R5
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_SAMPLE) |-> (win_q <= WIN_LAST)); // R3
    AST_SAMPLE_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BS_SAMPLE && bod_s) |=> bod_rst); // R5

endmodule

// File: rtl/ext_rst_filt.sv
module ext_rst_filt
    import rst_src_pkg::*;
#(
    parameter int MIN_LOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low,
    output logic ext_rst
);

    localparam int CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'((MIN_LOW < 2) ? 0 : MIN_LOW - 1);

    ext_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            EX_IDLE: begin
                if (pin_low) begin
                    if (MIN_LOW <= 1) begin
                        st_d = EX_ASSERT;
                    end else begin
                        st_d  = EX_COUNT;
                        cnt_d = CW'(1);
                    end
                end
            end
            EX_COUNT: begin
                if (!pin_low) begin
                    st_d = EX_IDLE;
                end else if (cnt_q == CNT_LAST) begin
                    st_d = EX_ASSERT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            EX_ASSERT: begin
                if (!pin_low) st_d = EX_IDLE;
            end
            default: st_d = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= EX_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        ext_rst = (st_q == EX_ASSERT);
    end

    AST_EXT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_rst) |-> $past(pin_low)); // R6
    AST_EXT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst && !pin_low) |=> !ext_rst); // R6

endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch
    import rst_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fast_tick,
    input  logic wdt_evt,
    output logic wdt_rst
);

    wdt_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_IDLE:   if (wdt_evt)   st_d = WD_FIRST;
            WD_FIRST:  if (fast_tick) st_d = WD_SECOND;
            WD_SECOND: if (fast_tick) st_d = WD_IDLE;
            default:                  st_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        wdt_rst = (st_q != WD_IDLE);
    end

    AST_WDT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_IDLE && wdt_evt) |=> wdt_rst); // R7
    AST_WDT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst && !fast_tick) |=> wdt_rst); // R7

endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rst_src_pkg::*;
#(
    parameter int SAMPLE_CYC = 4,
    parameter int EXT_MIN    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               fast_tick,
    input  logic               sleep_deep,
    input  logic               cfg_load,
    input  logic [1:0]         cfg_act,
    input  logic [1:0]         cfg_pd,
    input  logic               bod_flag,
    input  logic               ext_rst_n,
    input  logic               wdt_timeout,
    input  logic [CAUSE_W-1:0] cause_clr,
    output logic               bod_en,
    output logic               bod_sample,
    output logic               sys_rst,
    output logic [CAUSE_W-1:0] cause
);

    logic [1:0]         raw_s;
    logic               bod_s, pin_low;
    logic               bod_rst, ext_rst, wdt_rst;
    logic [CAUSE_W-1:0] src_vec;
    logic [CAUSE_W-1:0] cause_q;
    logic               sys_rst_q;

    // bit 1 = pin (idles high), bit 0 = brownout flag (idles low)
    rst_sync2 #(.W(2), .INIT(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_rst_n, bod_flag}),
        .q     (raw_s)
    );

    assign bod_s   = raw_s[0];
    assign pin_low = ~raw_s[1];

    bod_ctrl #(.SAMPLE_CYC(SAMPLE_CYC)) u_bod (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_tick  (slow_tick),
        .sleep_deep (sleep_deep),
        .cfg_load   (cfg_load),
        .cfg_act    (cfg_act),
        .cfg_pd     (cfg_pd),
        .bod_s      (bod_s),
        .bod_en     (bod_en),
        .bod_sample (bod_sample),
        .bod_rst    (bod_rst)
    );

    ext_rst_filt #(.MIN_LOW(EXT_MIN)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_low (pin_low),
        .ext_rst (ext_rst)
    );

    wdt_stretch u_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .wdt_evt   (wdt_timeout),
        .wdt_rst   (wdt_rst)
    );

    always_comb begin
        src_vec            = '0;
        src_vec[CAUSE_BOD] = bod_rst;
        src_vec[CAUSE_EXT] = ext_rst;
        src_vec[CAUSE_WDT] = wdt_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_rst_q <= 1'b1;
            cause_q   <= '0;
        end else begin
            sys_rst_q <= |src_vec;
            cause_q   <= (cause_q & ~cause_clr) | src_vec;
        end
    end

    assign sys_rst = sys_rst_q;
    assign cause   = cause_q;

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(cause_q & ~cause_clr)) == $past(cause_q & ~cause_clr))); // R9
    AST_RST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> (cause_q != '0)); // R9
    AST_SRC_GIVES_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_vec) |=> sys_rst); // R8

endmodule

// File: tb/tb_rst_src_ctrl.sv
module tb_rst_src_ctrl;

    localparam int WIN = 3;
    localparam int MINL = 4;
    localparam int FT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick;
    logic       sleep_deep = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_act = 2'b00;
    logic [1:0] cfg_pd = 2'b00;
    logic       bod_flag = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic [2:0] cause_clr = 3'b000;
    logic       bod_en, bod_sample, sys_rst;
    logic [2:0] cause;

    int n_chk = 0;
    int n_fail = 0;
    int ft_cnt = 0;
    int rst_cnt = 0;
    int samp_cnt = 0;
    logic mon_clr = 1'b0;

    rst_src_ctrl #(.SAMPLE_CYC(WIN), .EXT_MIN(MINL)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .sleep_deep(sleep_deep), .cfg_load(cfg_load), .cfg_act(cfg_act),
        .cfg_pd(cfg_pd), .bod_flag(bod_flag), .ext_rst_n(ext_rst_n),
        .wdt_timeout(wdt_timeout), .cause_clr(cause_clr), .bod_en(bod_en),
        .bod_sample(bod_sample), .sys_rst(sys_rst), .cause(cause)
    );

    always #5 clk = ~clk;

    always @(posedge clk) ft_cnt <= (ft_cnt == FT - 1) ? 0 : ft_cnt + 1;
    assign fast_tick = (ft_cnt == 0);

    always @(posedge clk) begin
        if (mon_clr) begin
            rst_cnt  <= 0;
            samp_cnt <= 0;
        end else begin
            if (sys_rst) rst_cnt <= rst_cnt + 1;
            if (bod_sample) samp_cnt <= samp_cnt + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [1:0] a, input logic [1:0] p);
        cfg_act = a; cfg_pd = p; cfg_load = 1'b1;
        step(1);
        cfg_load = 1'b0;
    endtask

    task automatic tick_slow();
        slow_tick = 1'b1;
        step(1);
        slow_tick = 1'b0;
    endtask

    task automatic clr_all();
        cause_clr = 3'b111;
        step(1);
        cause_clr = 3'b000;
        step(1);
    endtask

    task automatic mon_reset();
        mon_clr = 1'b1;
        step(1);
        mon_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        chk("R8 sys_rst during rst_n", int'(sys_rst), 1);
        chk("R9 cause at reset", int'(cause), 0);
        rst_n = 1'b1;
        step(4);
        chk("R8 power-up enabled mode", int'(bod_en), 1);
        chk("R8 sys_rst released", int'(sys_rst), 0);

        // R1/R2/R4/R5 sweep over both fields and both sleep selections
        for (int a = 0; a < 4; a++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 2; s++) begin
                    int m;
                    m = (s == 1) ? p : a;
                    sleep_deep = s[0];
                    load_cfg(a[1:0], p[1:0]);
                    step(4);
                    chk("R1 R2 bod_en steady", int'(bod_en), (m == 3) ? 1 : 0);
                    bod_flag = 1'b1;
                    step(6);
                    chk("R4 R1 flag reset before tick", int'(sys_rst), (m == 3) ? 1 : 0);
                    if (m == 1) begin
                        tick_slow();
                        step(WIN + 4);
                        chk("R5 sampled hit holds reset", int'(sys_rst), 1);
                        chk("R5 sampled hit forces enable", int'(bod_en), 1);
                    end
                    bod_flag = 1'b0;
                    step(5);
                    chk("R4 R5 reset released on recovery", int'(sys_rst), 0);
                    chk("R9 R1 brownout cause", int'(cause[0]), (m == 3 || m == 1) ? 1 : 0);
                    clr_all();
                    chk("R9 cause cleared", int'(cause), 0);
                end
            end
        end

        // R3 window length, flag low
        sleep_deep = 1'b0;
        load_cfg(2'b01, 2'b01);
        step(3);
        mon_reset();
        tick_slow();
        step(WIN + 3);
        chk("R3 window length", samp_cnt, WIN);
        chk("R3 no reset in clean window", rst_cnt, 0);
        chk("R3 detector off between ticks", int'(bod_en), 0);

        // R3 dip between ticks is not seen
        mon_reset();
        bod_flag = 1'b1;
        step(5);
        bod_flag = 1'b0;
        step(4);
        tick_slow();
        step(WIN + 3);
        chk("R3 dip between ticks ignored", rst_cnt, 0);
        chk("R3 dip leaves no cause", int'(cause[0]), 0);

        // R5 hold survives a change to disabled
        bod_flag = 1'b1;
        step(3);
        tick_slow();
        step(WIN + 3);
        load_cfg(2'b10, 2'b10);
        step(4);
        chk("R5 hold after cfg change sys_rst", int'(sys_rst), 1);
        chk("R5 hold after cfg change bod_en", int'(bod_en), 1);
        bod_flag = 1'b0;
        step(5);
        chk("R5 released to disabled sys_rst", int'(sys_rst), 0);
        chk("R5 released to disabled bod_en", int'(bod_en), 0);
        clr_all();

        // R6 pin pulse length sweep
        for (int l = 1; l <= MINL + 3; l++) begin
            mon_reset();
            ext_rst_n = 1'b0;
            step(l);
            ext_rst_n = 1'b1;
            step(8);
            chk("R6 pin reset length", rst_cnt, (l >= MINL) ? (l - MINL + 1) : 0);
            chk("R6 R9 pin cause", int'(cause[1]), (l >= MINL) ? 1 : 0);
            clr_all();
        end

        // R9 set wins over clear, survives the reset it records
        ext_rst_n = 1'b0;
        step(MINL + 4);
        cause_clr = 3'b010;
        step(1);
        cause_clr = 3'b000;
        step(1);
        chk("R9 set beats clear", int'(cause[1]), 1);
        ext_rst_n = 1'b1;
        step(6);
        chk("R6 reset drops with pin high", int'(sys_rst), 0);
        chk("R9 cause survives sys_rst", int'(cause), 2);
        clr_all();

        // R7 watchdog pulse over every tick phase
        for (int ph = 0; ph < FT; ph++) begin
            mon_reset();
            while (ft_cnt != ph) step(1);
            wdt_timeout = 1'b1;
            step(1);
            wdt_timeout = 1'b0;
            step(3 * FT);
            chk("R7 watchdog pulse in range", int'(rst_cnt > FT && rst_cnt <= 2 * FT), 1);
            chk("R7 R9 watchdog cause", int'(cause), 4);
            clr_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule